// File: doc/BRIEF.md
# Configuration Command and Status Unit

This block is a three-register command interface on a 32-bit register bus. Software first places an argument in a data register. It then writes a command word to a control register. The command is decoded on that same write and completes at once. Two exact command codes produce a one-cycle shutdown request or a one-cycle reset request. Every other code completes with an error. A status register records completion and error, and software can overwrite it to clear those flags.

The unit exists only on one board variant, which is selected by the `unit_present` strap. When the strap is low, the three offsets behave as invalid registers: reads return zero, writes change nothing, and each such access raises a one-cycle bad-access strobe. Offsets outside the three are not decoded by this block. They read as zero and raise no strobe.

Top module: `cfgcmd_unit`

## Requirements
- R1: After a synchronous reset, the data, control and status registers read zero, `rd_data` is zero, and `shutdown_req`, `reset_req` and `bad_access` are low.
- R2: The data register at offset 0xA0 stores all 32 written bits and returns them on a read.
- R3: A write to the control register at offset 0xA4 stores the written value with bits 19 and 18 forced to zero, and a read returns that stored value.
- R4: Every control write sets status bit 0 (complete). It replaces the earlier status value rather than merging with it.
- R5: When the stored control value equals 0xC0800000, `shutdown_req` is high for exactly the one cycle after the write, and the status becomes 1.
- R6: When the stored control value equals 0xC0900000, `reset_req` is high for exactly the one cycle after the write, and the status becomes 1. A written value of 0xC09C0000 also qualifies because of the R3 masking.
- R7: Any other stored control value sets the status to 3 (bit 1 = error) and raises neither request.
- R8: A write to the status register at offset 0xA8 stores only bits 1:0 of the written data.
- R9: With `unit_present` low, reads of offsets 0xA0, 0xA4 and 0xA8 return zero and writes to them change no state and raise no request. Each such access drives `bad_access` high for one cycle.
- R10: Read data is registered and appears in the cycle after `rd_en`. Offsets outside the three read as zero and never raise `bad_access`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_present | input | 1 | Board strap; high when the unit exists |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle reset request |
| bad_access | output | 1 | One-cycle strobe for an access to an absent register |

## Verification
Each result has one fixed point at which it is due. Register contents, the shutdown and reset pulses, and the bad-access strobe all come from flops loaded at the edge that samples the access, so they are due one edge after the strobe. Read data also takes one edge after `rd_en`. The bench drives each access on a falling edge, lets one rising edge pass, and compares at the next falling edge. It then removes the strobe and checks one more falling edge later that the pulses have returned low.

// File: rtl/cfgcmd_pkg.sv
package cfgcmd_pkg;
  localparam int CMD_W = 32;
  localparam logic [11:0] OFS_DATA = 12'hA0;
  localparam logic [11:0] OFS_CTRL = 12'hA4;
  localparam logic [11:0] OFS_STAT = 12'hA8;
  localparam logic [CMD_W-1:0] CODE_SHUTDOWN = 32'hC080_0000;
  localparam logic [CMD_W-1:0] CODE_RESET    = 32'hC090_0000;
  localparam logic [CMD_W-1:0] CTRL_KEEP     = ~(32'h3 << 18);
  localparam int STAT_W = 2;

  typedef struct packed {
    logic data;
    logic ctrl;
    logic stat;
  } cfg_sel_t;
endpackage

// File: rtl/cfgcmd_decode.sv
module cfgcmd_decode
  import cfgcmd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              present,
  input  logic              wr_en,
  input  logic              rd_en,
  output cfg_sel_t          sel,
  output logic              bad_hit
);
  logic hit_data, hit_ctrl, hit_stat, hit_any;

  always_comb begin
    hit_data = (addr == ADDR_W'(OFS_DATA));
    hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
    hit_stat = (addr == ADDR_W'(OFS_STAT));
    hit_any  = hit_data | hit_ctrl | hit_stat;
    sel.data = hit_data & present;
    sel.ctrl = hit_ctrl & present;
    sel.stat = hit_stat & present;
    bad_hit  = hit_any & ~present & (wr_en | rd_en);
  end
endmodule

// File: rtl/cfgcmd_engine.sv
module cfgcmd_engine
  import cfgcmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [STAT_W-1:0] stat_q,
  output logic              shutdown_req,
  output logic              reset_req
);
  logic [DATA_W-1:0] ctrl_next;
  logic              is_shut, is_rst;

  always_comb begin
    ctrl_next = wr_data & DATA_W'(CTRL_KEEP);
    is_shut   = (ctrl_next == DATA_W'(CODE_SHUTDOWN));
    is_rst    = (ctrl_next == DATA_W'(CODE_RESET));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q       <= '0;
      stat_q       <= '0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
    end else begin
      shutdown_req <= ctrl_wr & is_shut;
      reset_req    <= ctrl_wr & is_rst;
      if (ctrl_wr) begin
        ctrl_q <= ctrl_next;
        stat_q <= (is_shut | is_rst) ? 2'b01 : 2'b11;
      end else if (stat_wr) begin
        stat_q <= wr_data[STAT_W-1:0];
      end
    end
  end

  // R5 / R6: requests are single-cycle pulses
  a_r5_shutdown_single: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |=> !shutdown_req || $past(ctrl_wr));
  a_r6_reset_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(shutdown_req && reset_req));
  // R4: a command write always leaves complete set
  a_r4_complete_set: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> stat_q[0]);
  // R7: error and a request never coexist right after a command
  a_r7_error_no_req: assert property (@(posedge clk) disable iff (rst)
    (shutdown_req || reset_req) |-> stat_q == 2'b01);
  // R3: masked bits never stored
  a_r3_mask_held: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[19:18] == 2'b00);
endmodule

// File: rtl/cfgcmd_unit.sv
module cfgcmd_unit
  import cfgcmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              unit_present,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              shutdown_req,
  output logic              reset_req,
  output logic              bad_access
);
  cfg_sel_t          sel;
  logic              bad_hit;
  logic [DATA_W-1:0] data_q, ctrl_q;
  logic [STAT_W-1:0] stat_q;
  logic [DATA_W-1:0] rd_mux;

  cfgcmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .present(unit_present), .wr_en(wr_en), .rd_en(rd_en),
    .sel(sel), .bad_hit(bad_hit)
  );

  cfgcmd_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst),
    .ctrl_wr(wr_en & sel.ctrl), .stat_wr(wr_en & sel.stat),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .shutdown_req(shutdown_req), .reset_req(reset_req)
  );

  always_comb begin
    rd_mux = '0;
    if (sel.data) rd_mux = data_q;
    if (sel.ctrl) rd_mux = ctrl_q;
    if (sel.stat) rd_mux = DATA_W'(stat_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q     <= '0;
      rd_data    <= '0;
      bad_access <= 1'b0;
    end else begin
      bad_access <= bad_hit;
      if (wr_en && sel.data) data_q <= wr_data;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  // R9: absent unit leaves state untouched and flags the access
  a_r9_absent_stable: assert property (@(posedge clk) disable iff (rst)
    !unit_present |=> $stable(data_q) && $stable(ctrl_q) && $stable(stat_q));
  a_r9_strobe_cause: assert property (@(posedge clk) disable iff (rst)
    bad_access |-> $past(!unit_present && (wr_en || rd_en)));
  a_r9_no_request: assert property (@(posedge clk) disable iff (rst)
    !unit_present |=> !shutdown_req && !reset_req);
  // R10: read data only changes after a read strobe
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/cfgcmd_unit_tb_top.sv
`timescale 1ns/1ps
module cfgcmd_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        unit_present;
  logic        wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        shutdown_req, reset_req, bad_access;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_data, m_ctrl;
  logic [1:0]  m_stat;

  always #2 clk = ~clk;

  cfgcmd_unit dut_i (
    .clk(clk), .rst(rst), .unit_present(unit_present),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .shutdown_req(shutdown_req), .reset_req(reset_req),
    .bad_access(bad_access)
  );

  function automatic logic [31:0] exp_ctrl(input logic [31:0] v);
    return v & 32'hFFF3_FFFF;
  endfunction
  function automatic logic [1:0] exp_kind(input logic [31:0] v);
    logic [31:0] c;
    c = exp_ctrl(v);
    if (c == 32'hC080_0000) return 2'd1;
    if (c == 32'hC090_0000) return 2'd2;
    return 2'd0;
  endfunction
  function automatic logic is_unit(input logic [11:0] a);
    return a == 12'hA0 || a == 12'hA4 || a == 12'hA8;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    logic [1:0] k;
    logic hit;
    hit = is_unit(a);
    k = (unit_present && a == 12'hA4) ? exp_kind(d) : 2'd0;
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    if (unit_present) begin
      if (a == 12'hA0) m_data = d;
      if (a == 12'hA4) begin m_ctrl = exp_ctrl(d); m_stat = (k != 0) ? 2'b01 : 2'b11; end
      if (a == 12'hA8) m_stat = d[1:0];
    end
    check("R5 shutdown pulse", {31'd0, shutdown_req}, {31'd0, k == 2'd1});
    check("R6 reset pulse", {31'd0, reset_req}, {31'd0, k == 2'd2});
    check("R9 bad strobe on write", {31'd0, bad_access}, {31'd0, hit && !unit_present});
    @(negedge clk);
    check("R5 R6 pulse ends", {30'd0, shutdown_req, reset_req}, 32'd0);
    check("R9 strobe ends", {31'd0, bad_access}, 32'd0);
  endtask

  task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string req);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    check(req, rd_data, exp);
    check("R9 R10 read strobe", {31'd0, bad_access}, {31'd0, is_unit(a) && !unit_present});
  endtask

  task automatic read_all(input string req);
    do_read(12'hA0, unit_present ? m_data : 32'd0, req);
    do_read(12'hA4, unit_present ? m_ctrl : 32'd0, req);
    do_read(12'hA8, unit_present ? {30'd0, m_stat} : 32'd0, req);
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    rst = 1'b1; unit_present = 1'b1; wr_en = 0; rd_en = 0; addr = '0; wr_data = '0;
    m_data = 0; m_ctrl = 0; m_stat = 0;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {rd_data[28:0], shutdown_req, reset_req, bad_access}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    read_all("R1 reset value");

    do_write(12'hA0, 32'hDEAD_BEEF); do_read(12'hA0, 32'hDEAD_BEEF, "R2 data reg");
    do_write(12'hA4, 32'hFFFF_FFFF); do_read(12'hA4, 32'hFFF3_FFFF, "R3 ctrl mask");
    do_read(12'hA8, 32'd3, "R7 error status");
    do_write(12'hA8, 32'hFFFF_FFFC); do_read(12'hA8, 32'd0, "R8 status low bits");
    do_write(12'hA8, 32'h0000_0006); do_read(12'hA8, 32'd2, "R8 status low bits");
    do_write(12'hA4, 32'hC080_0000); do_read(12'hA8, 32'd1, "R4 R5 shutdown status");
    do_write(12'hA8, 32'd3);
    do_write(12'hA4, 32'hC090_0000); do_read(12'hA8, 32'd1, "R4 R6 status replaced");
    do_write(12'hA4, 32'hC09C_0000); do_read(12'hA4, 32'hC090_0000, "R6 masked reset code");
    do_write(12'hA4, 32'hC080_0001); do_read(12'hA8, 32'd3, "R7 near code errors");
    do_read(12'h0A4 + 12'h100, 32'd0, "R10 other offset");
    do_write(12'h0B0, 32'h1234_5678); read_all("R10 other offset write");

    unit_present = 1'b0;
    do_write(12'hA0, 32'h5555_AAAA);
    do_write(12'hA4, 32'hC080_0000);
    do_write(12'hA8, 32'd0);
    read_all("R9 absent reads zero");
    unit_present = 1'b1;
    read_all("R9 absent writes ignored");

    seed_dummy = $urandom(32'd1234);
    for (int i = 0; i < 300; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      int sel;
      sel = $urandom_range(0, 4);
      a = (sel == 0) ? 12'hA0 : (sel == 1) ? 12'hA4 : (sel == 2) ? 12'hA8 :
          (sel == 3) ? 12'hA4 : 12'h0AC;
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d = ($urandom_range(0, 1) != 0) ? 32'hC080_0000 : 32'hC094_0000;
      unit_present = ($urandom_range(0, 4) != 0);
      if ($urandom_range(0, 1) != 0) do_write(a, d);
      else do_read(a, (unit_present && is_unit(a)) ?
                   ((a == 12'hA0) ? m_data : (a == 12'hA4) ? m_ctrl : {30'd0, m_stat}) : 32'd0,
                   "R2 R3 R4 R7 R8 R9 random read");
    end
    unit_present = 1'b1;
    read_all("R2 R3 R8 final state");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule